// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block sequences the operating mode of a digital phase-locked loop. It watches a small set of events from the reference-selection and phase-detection logic: an input has been chosen, the chosen input has been replaced by another, no qualified input remains, and the loop reports lock. From these it steps through six automatic modes: Free-Run, Pre-Locked, Locked, Pre-Locked2 (re-acquisition after an input change), Lost-Phase (re-acquisition after loss of lock on the same input) and Holdover. A 5-bit control word either leaves the sequencing automatic or pins the loop into one mode. One code selects a direct frequency-write mode for an external servo.

The present mode is always reported on a 5-bit status field. Each mode change sets a sticky change flag. The flag drives an interrupt line only when a mask bit allows it. A 2-bit stage select tells the loop filter which bandwidth and damping set to use. The start set is used for a fixed window after each fresh acquisition begins. The acquisition set follows until lock, and the locked set is used while Locked. The window is counted in system clocks. Its length is the product of two parameters, the system clock rate and the window in seconds (two by default).

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After synchronous reset the status reads Free-Run (00001), the change flag, mask and interrupt are 0, and the stage select is start (00).
- R2: Status codes are Free-Run 00001, Holdover 00010, Locked 00100, Pre-Locked2 00101, Pre-Locked 00110 and Lost-Phase 00111. A control word equal to one of these codes puts that mode on the status one clock later, whatever the events are.
- R3: Control word 01010 selects direct frequency-write mode, reported as status 01010. Control word 00000 and every other unlisted code give automatic sequencing. In automatic sequencing, the direct frequency-write mode falls back to Free-Run.
- R4: In automatic sequencing, Free-Run moves to Pre-Locked when an input is selected, and Pre-Locked moves to Locked when the lock indicator is high.
- R5: In Locked, a low lock indicator moves the mode to Lost-Phase, and Lost-Phase returns to Locked when lock is high again. Within Locked the priority is: no qualified input, then input switch, then loss of lock.
- R6: In Locked, an input switch moves the mode to Pre-Locked2, which moves to Locked when the lock indicator is high.
- R7: No qualified input moves Pre-Locked, Pre-Locked2, Locked and Lost-Phase to Holdover. Holdover moves to Pre-Locked when an input is selected. Free-Run stays in Free-Run when no qualified input is reported.
- R8: The change flag is set on every mode change and holds until an acknowledge pulse clears it. A change in the same clock as an acknowledge leaves the flag set.
- R9: The interrupt is the change flag gated by the mask bit. The mask is loaded when its write strobe is high.
- R10: Stage select is start (00) for WIN clocks after the mode enters Pre-Locked, Pre-Locked2 or Lost-Phase from any other mode, then acquisition (01) while that group is kept, locked (10) in Locked and start (00) in all other modes. WIN equals CLK_HZ times WIN_SEC.
- R11: Inputs sampled at one rising edge appear on all outputs immediately after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 5 | Mode control word (automatic, forced or frequency-write) |
| in_sel | input | 1 | An input reference has been selected |
| in_swap | input | 1 | Selected reference changed to another input |
| no_qual | input | 1 | No qualified reference is available |
| lock_in | input | 1 | Lock indicator from the phase detector |
| mask_we | input | 1 | Write strobe for the interrupt mask |
| mask_d | input | 1 | Mask value to write |
| chg_ack | input | 1 | Clears the sticky change flag |
| mode_stat | output | 5 | Current mode code |
| chg_flag | output | 1 | Sticky mode-change flag |
| irq | output | 1 | Interrupt request |
| bw_stage | output | 2 | Loop bandwidth stage: 00 start, 01 acquisition, 10 locked |

## Verification
The hardest situation to reach is the end of the start window. It needs the loop to stay in an acquisition mode for exactly WIN clocks, with the window restarted by re-entry from Locked. The bench shrinks the window to 16 clocks through the clock-rate parameter and holds the lock indicator low across it. It samples the clock just before and just after the switch to acquisition. It then leaves Locked through both Lost-Phase and Pre-Locked2 to confirm that the window restarts. Priority collisions are driven too: switch, loss of lock and loss of all inputs together, and an acknowledge in the same clock as a new mode change.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

  typedef enum logic [4:0] {
    MODE_FREE = 5'b00001,
    MODE_HOLD = 5'b00010,
    MODE_LOCK = 5'b00100,
    MODE_PLK2 = 5'b00101,
    MODE_PLK  = 5'b00110,
    MODE_LOST = 5'b00111,
    MODE_DCO  = 5'b01010
  } mode_e;

  typedef enum logic [1:0] {
    BW_START = 2'b00,
    BW_ACQ   = 2'b01,
    BW_LOCK  = 2'b10
  } bw_e;

  // control word names a concrete mode (forced or frequency-write)
  function automatic logic cfg_pins_mode(input logic [4:0] c);
    case (c)
      5'b00001, 5'b00010, 5'b00100, 5'b00101,
      5'b00110, 5'b00111, 5'b01010: cfg_pins_mode = 1'b1;
      default:                      cfg_pins_mode = 1'b0;
    endcase
  endfunction

  // modes in which the loop is (re)acquiring
  function automatic logic mode_is_acq(input mode_e m);
    mode_is_acq = (m == MODE_PLK) || (m == MODE_PLK2) || (m == MODE_LOST);
  endfunction

endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] cfg_i,
  input  logic       sel_i,
  input  logic       swap_i,
  input  logic       noq_i,
  input  logic       lock_i,
  output mode_e      mode_q,
  output mode_e      mode_d
);

  always_comb begin
    mode_d = mode_q;
    if (cfg_pins_mode(cfg_i)) begin
      mode_d = mode_e'(cfg_i);
    end else begin
      case (mode_q)
        MODE_FREE: if (sel_i) mode_d = MODE_PLK;
        MODE_HOLD: if (sel_i) mode_d = MODE_PLK;
        MODE_PLK, MODE_PLK2, MODE_LOST: begin
          if (noq_i)       mode_d = MODE_HOLD;
          else if (lock_i) mode_d = MODE_LOCK;
        end
        MODE_LOCK: begin
          if (noq_i)        mode_d = MODE_HOLD;
          else if (swap_i)  mode_d = MODE_PLK2;
          else if (!lock_i) mode_d = MODE_LOST;
        end
        default: mode_d = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_FREE;
    else     mode_q <= mode_d;
  end

  // R2
  forced_mode_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_pins_mode(cfg_i) |=> (mode_q == mode_e'($past(cfg_i))));

  // R4
  free_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pins_mode(cfg_i) && mode_q == MODE_FREE && !sel_i) |=> (mode_q == MODE_FREE));

  // R5
  lost_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pins_mode(cfg_i) && mode_q == MODE_LOCK && !lock_i && !noq_i && !swap_i)
      |=> (mode_q == MODE_LOST));

  // R7
  holdover_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pins_mode(cfg_i) && noq_i && (mode_is_acq(mode_q) || mode_q == MODE_LOCK))
      |=> (mode_q == MODE_HOLD));

endmodule

// File: rtl/dpll_bw_stager.sv
module dpll_bw_stager
  import dpll_mode_pkg::*;
#(
  parameter int WIN = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  mode_e mode_q,
  input  mode_e mode_d,
  output bw_e  bw_q
);

  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WIN);

  logic [CW-1:0] cnt_q, cnt_d;
  bw_e           bw_d;

  always_comb begin
    cnt_d = '0;
    if (mode_is_acq(mode_d) && mode_is_acq(mode_q))
      cnt_d = (cnt_q == WIN_C) ? cnt_q : cnt_q + 1'b1;
    if (mode_d == MODE_LOCK)
      bw_d = BW_LOCK;
    else if (mode_is_acq(mode_d))
      bw_d = (cnt_d < WIN_C) ? BW_START : BW_ACQ;
    else
      bw_d = BW_START;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bw_q  <= BW_START;
    end else begin
      cnt_q <= cnt_d;
      bw_q  <= bw_d;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= WIN_C);

  // R10
  locked_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LOCK) |-> (bw_q == BW_LOCK));

  // R10
  idle_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_is_acq(mode_q) && mode_q != MODE_LOCK) |-> (bw_q == BW_START));

endmodule

// File: rtl/dpll_mode_irq.sv
module dpll_mode_irq
  import dpll_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_q,
  input  mode_e mode_d,
  input  logic  ack_i,
  input  logic  mask_we_i,
  input  logic  mask_d_i,
  output logic  flag_q,
  output logic  irq_q
);

  logic mask_q, mask_n, flag_n;

  always_comb begin
    mask_n = mask_we_i ? mask_d_i : mask_q;
    flag_n = (mode_d != mode_q) | (flag_q & ~ack_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      flag_q <= flag_n;
      irq_q  <= flag_n & mask_n;
    end
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_d != mode_q) |=> flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ack_i) |=> flag_q);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (mask_q && flag_q));

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int CLK_HZ  = 25_000_000,
  parameter int WIN_SEC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] mode_cfg,
  input  logic       in_sel,
  input  logic       in_swap,
  input  logic       no_qual,
  input  logic       lock_in,
  input  logic       mask_we,
  input  logic       mask_d,
  input  logic       chg_ack,
  output logic [4:0] mode_stat,
  output logic       chg_flag,
  output logic       irq,
  output logic [1:0] bw_stage
);

  localparam int WIN = CLK_HZ * WIN_SEC;

  mode_e cur_mode, nxt_mode;
  bw_e   stage;

  dpll_mode_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .cfg_i  (mode_cfg),
    .sel_i  (in_sel),
    .swap_i (in_swap),
    .noq_i  (no_qual),
    .lock_i (lock_in),
    .mode_q (cur_mode),
    .mode_d (nxt_mode)
  );

  dpll_bw_stager #(.WIN(WIN)) u_bw (
    .clk    (clk),
    .rst    (rst),
    .mode_q (cur_mode),
    .mode_d (nxt_mode),
    .bw_q   (stage)
  );

  dpll_mode_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (cur_mode),
    .mode_d    (nxt_mode),
    .ack_i     (chg_ack),
    .mask_we_i (mask_we),
    .mask_d_i  (mask_d),
    .flag_q    (chg_flag),
    .irq_q     (irq)
  );

  assign mode_stat = cur_mode;
  assign bw_stage  = stage;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (mode_stat == 5'b00001 && !chg_flag && !irq && bw_stage == 2'b00));

endmodule

// File: tb/test_dpll_mode_ctrl.sv
module test_dpll_mode_ctrl;

  localparam int HZ = 8;
  localparam int SEC = 2;
  localparam int W = HZ * SEC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] mode_cfg = 5'd0;
  logic       in_sel = 0, in_swap = 0, no_qual = 0, lock_in = 0;
  logic       mask_we = 0, mask_d = 0, chg_ack = 0;
  logic [4:0] mode_stat;
  logic       chg_flag, irq;
  logic [1:0] bw_stage;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit armed = 0;
  bit done = 0;

  // behavioural reference state
  int m_mode = 1, m_cnt = 0, m_bw = 0, m_flag = 0, m_mask = 0, m_irq = 0;

  always #5 clk = ~clk;

  dpll_mode_ctrl #(.CLK_HZ(HZ), .WIN_SEC(SEC)) i_dpll_mode_ctrl (
    .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .in_sel(in_sel),
    .in_swap(in_swap), .no_qual(no_qual), .lock_in(lock_in),
    .mask_we(mask_we), .mask_d(mask_d), .chg_ack(chg_ack),
    .mode_stat(mode_stat), .chg_flag(chg_flag), .irq(irq), .bw_stage(bw_stage)
  );

  function automatic bit acq(int m);
    return (m == 6) || (m == 5) || (m == 7);
  endfunction

  function automatic int model_next(int m, int c);
    if (c == 1 || c == 2 || c == 4 || c == 5 || c == 6 || c == 7 || c == 10) return c;
    if (m == 1 || m == 2) return in_sel ? 6 : m;
    if (m == 4) begin
      if (no_qual) return 2;
      if (in_swap) return 5;
      return lock_in ? 4 : 7;
    end
    if (acq(m)) begin
      if (no_qual) return 2;
      return lock_in ? 4 : m;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 1; m_cnt = 0; m_bw = 0; m_flag = 0; m_mask = 0; m_irq = 0;
    end else begin
      int nm;
      nm = model_next(m_mode, int'(mode_cfg));
      if (acq(nm) && acq(m_mode)) m_cnt = (m_cnt >= W) ? W : m_cnt + 1;
      else m_cnt = 0;
      if (nm == 4) m_bw = 2;
      else if (acq(nm)) m_bw = (m_cnt < W) ? 0 : 1;
      else m_bw = 0;
      if (mask_we) m_mask = int'(mask_d);
      m_flag = (nm != m_mode) ? 1 : (chg_ack ? 0 : m_flag);
      m_irq = m_flag & m_mask;
      m_mode = nm;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (armed && !rst) begin
      chk("R2 mode vs model", int'(mode_stat), m_mode);
      chk("R8 flag vs model", int'(chg_flag), m_flag);
      chk("R9 irq vs model", int'(irq), m_irq);
      chk("R10 stage vs model", int'(bw_stage), m_bw);
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    rst = 0;
    armed = 1;
    #3;
    // R1 reset state
    chk("R1 mode", int'(mode_stat), 1);
    chk("R1 flag", int'(chg_flag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 stage", int'(bw_stage), 0);
    tick();
    // R11: output holds until the sampling edge
    in_sel = 1;
    #3;
    chk("R11 before edge", int'(mode_stat), 1);
    tick();
    in_sel = 0;
    chk("R4 free->prelocked", int'(mode_stat), 6);
    chk("R8 flag set", int'(chg_flag), 1);
    chk("R10 start stage", int'(bw_stage), 0);
    tick(15);
    chk("R10 last start clock", int'(bw_stage), 0);
    tick();
    chk("R10 acquisition stage", int'(bw_stage), 1);
    mask_we = 1; mask_d = 1;
    tick();
    mask_we = 0;
    chk("R9 irq unmasked", int'(irq), 1);
    chg_ack = 1;
    tick();
    chg_ack = 0;
    chk("R8 flag cleared", int'(chg_flag), 0);
    chk("R9 irq follows flag", int'(irq), 0);
    lock_in = 1;
    tick();
    chk("R4 prelocked->locked", int'(mode_stat), 4);
    chk("R10 locked stage", int'(bw_stage), 2);
    lock_in = 0;
    tick();
    chk("R5 locked->lost", int'(mode_stat), 7);
    chk("R10 window restarts", int'(bw_stage), 0);
    lock_in = 1;
    tick();
    chk("R5 lost->locked", int'(mode_stat), 4);
    in_swap = 1; lock_in = 0;
    tick();
    in_swap = 0;
    chk("R6 locked->prelocked2", int'(mode_stat), 5);
    tick(4);
    chk("R6 waits for lock", int'(mode_stat), 5);
    lock_in = 1;
    tick();
    chk("R6 prelocked2->locked", int'(mode_stat), 4);
    no_qual = 1; in_swap = 1; lock_in = 0;
    tick();
    no_qual = 0; in_swap = 0;
    chk("R5 R7 priority to holdover", int'(mode_stat), 2);
    chg_ack = 1; in_sel = 1;
    tick();
    chg_ack = 0; in_sel = 0;
    chk("R7 holdover->prelocked", int'(mode_stat), 6);
    chk("R8 set wins over ack", int'(chg_flag), 1);
    mode_cfg = 5'b00001;
    tick();
    chk("R2 forced free-run", int'(mode_stat), 1);
    mode_cfg = 5'b00000; no_qual = 1;
    tick(2);
    no_qual = 0;
    chk("R7 free-run ignores no_qual", int'(mode_stat), 1);
    in_sel = 1; lock_in = 1; in_swap = 1;
    mode_cfg = 5'b00010; tick(); chk("R2 forced holdover", int'(mode_stat), 2);
    mode_cfg = 5'b00100; tick(); chk("R2 forced locked", int'(mode_stat), 4);
    mode_cfg = 5'b00101; tick(); chk("R2 forced prelocked2", int'(mode_stat), 5);
    mode_cfg = 5'b00110; tick(); chk("R2 forced prelocked", int'(mode_stat), 6);
    mode_cfg = 5'b00111; tick(); chk("R2 forced lost-phase", int'(mode_stat), 7);
    in_sel = 0; lock_in = 0; in_swap = 0;
    mode_cfg = 5'b01010; tick(); chk("R3 frequency-write mode", int'(mode_stat), 10);
    chk("R10 stage outside acquisition", int'(bw_stage), 0);
    mode_cfg = 5'b01011; tick(); chk("R3 reserved code falls back", int'(mode_stat), 1);
    mode_cfg = 5'b11111; in_sel = 1;
    tick();
    in_sel = 0;
    chk("R3 reserved code is automatic", int'(mode_stat), 6);
    mode_cfg = 5'b00000;
    tick(W + 3);
    chk("R10 acquisition after window", int'(bw_stage), 1);
    rst = 1;
    tick();
    rst = 0;
    chk("R1 reset again", int'(mode_stat), 1);
    chk("R1 mask cleared", int'(irq), 0);
    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule